// File: doc/BRIEF.md
# Byte-Write Synchronous SRAM Data Path

This block is the storage and data path of a flow-through synchronous SRAM. Every word is made of four byte lanes of nine bits: eight data bits plus one parity bit. An upstream address generator presents the word address and a chip-select. On the rising clock edge, the block captures the address, the write data and the write qualifiers in one input stage. A captured write is committed to the array at the close of the cycle in which it was captured. There is no separate write-recovery step.

Writes use three levels of qualification. An active-low global write stores all four lanes. Otherwise an active-low byte-write enable opens the four per-lane strobes, and each lane is written only when its own strobe is low. If neither global write nor byte-write enable is active, the selected cycle is a read. The read path has no output register. The word at the captured address is presented in the same cycle that the address was captured.

The shared data bus is modelled as a data output plus a drive-enable flag. An asynchronous active-low output enable gates the drive-enable flag directly. The default size is small, and the address width parameter scales the array to the full depth.

Top module: `sram_bytewrite_dp`

## Requirements
- R1: While reset is high, and after it is released until a read is captured, `rd_drive` is low.
- R2: A selected cycle with `glob_wr_n` low writes all 36 bits, including the four parity bits, whatever `byte_wr_n` and `lane_wr_n` are.
- R3: A selected cycle with `glob_wr_n` high and `byte_wr_n` low writes only the lanes whose `lane_wr_n` bit is low. Lane i occupies word bits 9i+8 down to 9i, and its parity bit is bit 9i+8. The other lanes keep their contents.
- R4: A selected cycle with `glob_wr_n` and `byte_wr_n` both high is a read. After that capturing edge, and within the same cycle, `rd_data` shows the stored word and `rd_drive` is high while `out_en_n` is low.
- R5: A cycle with `sel` low writes nothing and leaves `rd_drive` low.
- R6: In the cycle after a write is captured, `rd_drive` is low. This includes a byte write with all four lane strobes high, which stores nothing.
- R7: `out_en_n` high forces `rd_drive` low at once, without a clock edge. Lowering it again restores the drive and the data within the same cycle.
- R8: A read captured on the edge right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address from the address generator |
| sel | input | 1 | Chip selected this cycle (active high) |
| glob_wr_n | input | 1 | Global write, all lanes (active low) |
| byte_wr_n | input | 1 | Byte-write enable opening the lane strobes (active low) |
| lane_wr_n | input | LANES | Per-lane write strobes (active low) |
| wr_data | input | LANES*(LANE_DATA_W+1) | Write data, parity bit at the top of each lane |
| out_en_n | input | 1 | Asynchronous output enable (active low) |
| rd_data | output | LANES*(LANE_DATA_W+1) | Flow-through read data, zero while not driven |
| rd_drive | output | 1 | Data bus driver enable |

## Verification
Every address is first filled by global writes while the byte controls take scrambled values. Reading these back shows whether the global override really beats the byte-write enable. A byte-write sweep then applies all sixteen lane masks across the array over a known background, so each lane and its parity bit are shown to be written or held on their own. Deselected global writes and byte writes with every strobe high must leave old data in place. Back-to-back write-then-read pairs and an output enable toggled mid-cycle separate the flow-through timing from a registered-output or clock-gated one.

// File: rtl/sram_dp_pkg.sv
`timescale 1ns/1ps
package sram_dp_pkg;

    localparam int LANES_DEF       = 4;
    localparam int LANE_DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    // Decide what a cycle does from the select and the two write levels.
    function automatic cyc_kind_e classify(input logic sel,
                                           input logic glob_wr_n,
                                           input logic byte_wr_n);
        if (!sel)                       return CYC_IDLE;
        if (!glob_wr_n || !byte_wr_n)   return CYC_WRITE;
        return CYC_READ;
    endfunction

endpackage

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = LANES_DEF,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    input  logic              glob_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] data_q,
    output logic [LANES-1:0]  lane_we_q,
    output cyc_kind_e         kind_q
);

    cyc_kind_e        kind_d;
    logic [LANES-1:0] lane_we_d;

    always_comb kind_d = classify(sel, glob_wr_n, byte_wr_n);

    // Global write overrides the per-lane strobes; otherwise each lane obeys its strobe.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we_d[i] = (kind_d == CYC_WRITE) && (!glob_wr_n || !lane_wr_n[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q    <= CYC_IDLE;
            lane_we_q <= '0;
        end else begin
            kind_q    <= kind_d;
            lane_we_q <= lane_we_d;
        end
        addr_q <= addr;
        data_q <= wr_data;
    end

    assert_gw_all_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && !glob_wr_n) |=> ((&lane_we_q) && kind_q == CYC_WRITE));

    assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && glob_wr_n && !byte_wr_n) |=> (lane_we_q == ~$past(lane_wr_n)));

    assert_read_no_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && glob_wr_n && byte_wr_n) |=> (lane_we_q == '0 && kind_q == CYC_READ));

    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (lane_we_q == '0 && kind_q == CYC_IDLE));

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Commit of the captured write at the close of its cycle, lane by lane.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we[i]) begin
                mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // Flow-through read: no register between array and output.
    assign rdata = mem[raddr];

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        assert_lane_commit_R3: assert property (@(posedge clk) disable iff (rst)
            we[i] |=> (mem[$past(waddr)][i*LANE_W +: LANE_W] == $past(wdata[i*LANE_W +: LANE_W])));

        assert_lane_hold_R3: assert property (@(posedge clk) disable iff (rst)
            ((|we) && !we[i]) |=>
                (mem[$past(waddr)][i*LANE_W +: LANE_W] == $past(mem[waddr][i*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/sram_out_ctl.sv
`timescale 1ns/1ps
module sram_out_ctl
    import sram_dp_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              out_en_n,
    input  cyc_kind_e         kind_q,
    input  logic [WORD_W-1:0] arr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);

    // Asynchronous gate: no clock between the enable pin and the driver flag.
    always_comb begin
        rd_drive = !out_en_n && (kind_q == CYC_READ);
        rd_data  = rd_drive ? arr_data : '0;
    end

endmodule

// File: rtl/sram_bytewrite_dp.sv
`timescale 1ns/1ps
module sram_bytewrite_dp
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LANES       = LANES_DEF,
    parameter int LANE_DATA_W = LANE_DATA_W_DEF
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 sel,
    input  logic                                 glob_wr_n,
    input  logic                                 byte_wr_n,
    input  logic [LANES-1:0]                     lane_wr_n,
    input  logic [LANES*(LANE_DATA_W+1)-1:0]     wr_data,
    input  logic                                 out_en_n,
    output logic [LANES*(LANE_DATA_W+1)-1:0]     rd_data,
    output logic                                 rd_drive
);

    localparam int LANE_W = LANE_DATA_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] arr_data;
    logic [LANES-1:0]  lane_we_q;
    cyc_kind_e         kind_q;

    sram_in_stage #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_in (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .sel       (sel),
        .glob_wr_n (glob_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_wr_n (lane_wr_n),
        .wr_data   (wr_data),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .lane_we_q (lane_we_q),
        .kind_q    (kind_q)
    );

    sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (lane_we_q),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (arr_data)
    );

    sram_out_ctl #(
        .WORD_W (WORD_W)
    ) u_out (
        .out_en_n (out_en_n),
        .kind_q   (kind_q),
        .arr_data (arr_data),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && glob_wr_n && byte_wr_n) |=> (out_en_n || rd_drive));

    assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !rd_drive);

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (sel && (!glob_wr_n || !byte_wr_n)) |=> !rd_drive);

endmodule

// File: tb/sim_sram_bytewrite_dp.sv
`timescale 1ns/1ps
module sim_sram_bytewrite_dp;

    localparam int AW    = 8;
    localparam int NL    = 4;
    localparam int LW    = 9;
    localparam int WW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel = 1'b0;
    logic          glob_wr_n = 1'b1;
    logic          byte_wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic [WW-1:0] wr_data = '0;
    logic          out_en_n = 1'b0;
    logic [WW-1:0] rd_data;
    logic          rd_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [WW-1:0] model [DEPTH];

    always #2 clk = ~clk;

    sram_bytewrite_dp #(.ADDR_W(AW), .LANES(NL), .LANE_DATA_W(LW-1)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .sel(sel),
        .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
        .wr_data(wr_data), .out_en_n(out_en_n),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic logic [WW-1:0] pat(int a, int s);
        logic [63:0] x;
        x = 64'(a) * 64'd2654435761 + 64'(s) * 64'd40503 + 64'(a ^ s) * 64'h1_0000_0000;
        return x[WW-1:0] ^ x[63:28];
    endfunction

    function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw,
                                            logic [NL-1:0] strobes_n);
        logic [WW-1:0] r;
        r = old;
        for (int i = 0; i < NL; i++) begin
            if (!strobes_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one write-class cycle; shortly after its capturing edge the driver must be off.
    task automatic wr(int a, bit s, bit g, bit b, logic [NL-1:0] bw, logic [WW-1:0] d, string req);
        @(negedge clk);
        addr = a[AW-1:0]; sel = s; glob_wr_n = g; byte_wr_n = b; lane_wr_n = bw; wr_data = d;
        @(posedge clk);
        #1;
        check(rd_drive == 1'b0, req, {{(WW-1){1'b0}}, rd_drive}, '0);
    endtask

    // Drive a read; sample half a cycle after the capturing edge (flow-through).
    task automatic rd(int a, string req);
        @(negedge clk);
        addr = a[AW-1:0]; sel = 1'b1; glob_wr_n = 1'b1; byte_wr_n = 1'b1; lane_wr_n = '1;
        @(negedge clk);
        check(rd_drive == 1'b1 && rd_data == model[a], req, rd_data, model[a]);
    endtask

    initial begin
        // R1: reset dominates a selected read request
        sel = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_drive == 1'b0, "R1", {{(WW-1){1'b0}}, rd_drive}, '0);
        sel = 1'b0;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(rd_drive == 1'b0, "R1", {{(WW-1){1'b0}}, rd_drive}, '0);

        // R2: global writes everywhere with scrambled byte controls
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, 1'b1, 1'b0, a[0], 4'(a >> 4), pat(a, 1), "R6");
            model[a] = pat(a, 1);
        end
        for (int a = 0; a < DEPTH; a++) rd(a, "R2");

        // R3: byte writes covering all sixteen lane masks (mask 4'hF writes nothing, R6)
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, 1'b1, 1'b1, 1'b0, 4'(a), pat(a, 2), "R6");
            model[a] = merge(model[a], pat(a, 2), 4'(a));
        end
        for (int a = 0; a < DEPTH; a++) rd(a, "R3");

        // R5: deselected writes are ignored and never drive
        for (int a = 0; a < 16; a++) wr(a, 1'b0, 1'b0, 1'b0, 4'h0, pat(a, 4), "R5");
        for (int a = 0; a < 16; a++) rd(a, "R5");

        // R8: read on the edge right after a write to the same address
        for (int a = 32; a < 64; a++) begin
            wr(a, 1'b1, 1'b0, 1'b1, 4'hF, pat(a, 5), "R6");
            model[a] = pat(a, 5);
            rd(a, "R8");
        end

        // R7: output enable toggled inside a read cycle, no clock edge in between
        for (int a = 64; a < 68; a++) begin
            rd(a, "R4");
            #0.5 out_en_n = 1'b1;
            #0.5;
            check(rd_drive == 1'b0, "R7", {{(WW-1){1'b0}}, rd_drive}, '0);
            out_en_n = 1'b0;
            #0.5;
            check(rd_drive == 1'b1 && rd_data == model[a], "R7", rd_data, model[a]);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule